// File: doc/BRIEF.md
# 32-Pin Memory-Mapped GPIO Controller

This block is a general-purpose I/O peripheral for 32 pins. Software reaches it through a word-addressed register port. For each pin, software sets an output value, a drive enable and an open-drain enable. Two 2-bit source selects per pin decide where the pin's value and its enable come from. Software can also read back the pin levels after a two-stage synchronizer.

Each pin's output value and output enable can come from the software registers or from one of three alternate-function inputs. The pin port of the block has three vectors: a pad output, a pad output enable and a pad input. Each vector is indexed by pin number. In every 1-bit-per-pin register, pin 0 sits at the most significant bit. Several register words have no function behind them; they are plain read/write storage.

Top module: `pinbank_top`

## Requirements
- R1: After reset every writable register reads 0 and pad_oe_o is all 0. All pins therefore float, with the software source selected.
- R2: In every 1-bit-per-pin register, pin n is bit 31-n. In pad_out_o, pad_oe_o, pad_in_i, alt_val_i[k] and alt_oe_i[k], pin n is bit n.
- R3: Word indices on addr_i are as follows. 0 is the output value and 1 is the drive enable. 2 and 3 are the value select for pins 0-15 and 16-31. 4 and 5 are the enable select for pins 0-15 and 16-31. 6 is the open-drain enable and 7 is the input word. 8 to 10 are storage words, 11 is reserved, and 12 to 17 are storage words. Indices 18 to 31 read 0 and ignore writes.
- R4: In a select word, pin n owns bits [31-2*(n mod 16) : 30-2*(n mod 16)]. Pins 0-15 use the low word and pins 16-31 use the high word.
- R5: Select code 00 takes the value from the output register and the enable from the drive register. An enable of 1 drives the pin and an enable of 0 floats it.
- R6: Select codes 01, 10 and 11 take the value from alt_val_i[0], [1] or [2] (value select). For the enable select, the same codes take the enable from alt_oe_i[0], [1] or [2].
- R7: When a pin's open-drain bit is 1, its pad_out_o is 0. Its pad_oe_o is 1 only when the selected enable is 1 and the selected value is 0.
- R8: Word 7 reflects pad_in_i through two flops. A pad change made between two rising edges shows on a read after exactly two rising edges, and not after one.
- R9: Writes to word 7 and word 11 have no effect. Word 11 always reads 0.
- R10: wr_en_i with be_i updates only the enabled bytes. be_i[b] covers bits [8b+7:8b].
- R11: Words 8-10 and 12-17 read back what was last written to them and drive no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 5 | Word index |
| be_i | input | 4 | Byte enables for a write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| alt_val_i | input | 3x32 | Alternate-function values; [k] is source k+1 |
| alt_oe_i | input | 3x32 | Alternate-function enables; [k] is source k+1 |
| pad_in_i | input | 32 | Pad levels, bit n is pin n |
| pad_out_o | output | 32 | Pad output value, bit n is pin n |
| pad_oe_o | output | 32 | Pad output enable, bit n is pin n |

## Verification
A corrupted register or select field shows up on pad_out_o or pad_oe_o in the same cycle the bad state is present, because the pin mux is purely combinational after the register flops. A wrong bit-reversal or a wrong field offset moves the effect to a different pin, so the bench compares all 32 pins against its own model after every write. A synchronizer fault shows as a read of word 7 that is one edge early or late. A byte-enable fault shows on the next read of the written word.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int NPIN  = 32;
  localparam int DW    = 32;
  localparam int AW    = 5;
  localparam int NWORD = 18;
  localparam int NALT  = 3;
  localparam int NBYTE = DW / 8;
  localparam int HALF  = NPIN / 2;

  typedef enum logic [AW-1:0] {
    W_OUT  = 5'd0,  W_DRV  = 5'd1,  W_OSL  = 5'd2,  W_OSH  = 5'd3,
    W_TSL  = 5'd4,  W_TSH  = 5'd5,  W_ODE  = 5'd6,  W_IN   = 5'd7,
    W_RX1  = 5'd8,  W_RX2  = 5'd9,  W_RX3  = 5'd10, W_RSV  = 5'd11,
    W_IS1L = 5'd12, W_IS1H = 5'd13, W_IS2L = 5'd14, W_IS2H = 5'd15,
    W_IS3L = 5'd16, W_IS3H = 5'd17
  } word_e;

  function automatic bit word_writable(int w);
    return (w != int'(W_IN)) && (w != int'(W_RSV)) && (w < NWORD);
  endfunction
endpackage

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [3:0]    be_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] in_word_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] out_w_o,
  output logic [DW-1:0] drv_w_o,
  output logic [DW-1:0] osl_w_o,
  output logic [DW-1:0] osh_w_o,
  output logic [DW-1:0] tsl_w_o,
  output logic [DW-1:0] tsh_w_o,
  output logic [DW-1:0] ode_w_o
);
  logic [DW-1:0] word_q [NWORD];

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    if (word_writable(w)) begin : g_rw
      logic hit;
      assign hit = wr_en_i && (addr_i == AW'(w));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          word_q[w] <= '0;
        end else if (hit) begin
          for (int b = 0; b < NBYTE; b++)
            if (be_i[b]) word_q[w][b*8 +: 8] <= wdata_i[b*8 +: 8];
        end
      end
    end else begin : g_ro
      assign word_q[w] = '0;
    end
  end

  always_comb begin
    if (addr_i == W_IN)                   rdata_o = in_word_i;
    else if (int'(addr_i) < NWORD)        rdata_o = word_q[addr_i];
    else                                  rdata_o = '0;
  end

  assign out_w_o = word_q[W_OUT];
  assign drv_w_o = word_q[W_DRV];
  assign osl_w_o = word_q[W_OSL];
  assign osh_w_o = word_q[W_OSH];
  assign tsl_w_o = word_q[W_TSL];
  assign tsh_w_o = word_q[W_TSH];
  assign ode_w_o = word_q[W_ODE];

  // R10
  no_be_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && be_i == 4'b0000) |=> ($stable(out_w_o) && $stable(drv_w_o) &&
                                      $stable(ode_w_o) && $stable(osl_w_o)));
  // R9
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == W_RSV) |-> (rdata_o == '0));
  // R3
  oor_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(addr_i) >= NWORD) |=> ($stable(out_w_o) && $stable(drv_w_o) &&
                                            $stable(tsh_w_o) && $stable(osh_w_o)));
endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;

  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= 2'd0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  // R8
  sync_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/pinbank_pinmux.sv
module pinbank_pinmux
  import pinbank_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [DW-1:0]             out_w_i,
  input  logic [DW-1:0]             drv_w_i,
  input  logic [DW-1:0]             osl_w_i,
  input  logic [DW-1:0]             osh_w_i,
  input  logic [DW-1:0]             tsl_w_i,
  input  logic [DW-1:0]             tsh_w_i,
  input  logic [DW-1:0]             ode_w_i,
  input  logic [NALT-1:0][NPIN-1:0] alt_val_i,
  input  logic [NALT-1:0][NPIN-1:0] alt_oe_i,
  output logic [NPIN-1:0]           pad_out_o,
  output logic [NPIN-1:0]           pad_oe_o
);
  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    localparam int RB = DW - 1 - n;               // MSB-first bit
    localparam int SB = DW - 2 - 2 * (n % HALF);  // field lsb
    logic [1:0] vsel, esel;
    logic       val, en, od;

    if (n < HALF) begin : g_lo
      assign vsel = osl_w_i[SB +: 2];
      assign esel = tsl_w_i[SB +: 2];
    end else begin : g_hi
      assign vsel = osh_w_i[SB +: 2];
      assign esel = tsh_w_i[SB +: 2];
    end

    always_comb begin
      case (vsel)
        2'b00:   val = out_w_i[RB];
        2'b01:   val = alt_val_i[0][n];
        2'b10:   val = alt_val_i[1][n];
        default: val = alt_val_i[2][n];
      endcase
      case (esel)
        2'b00:   en = drv_w_i[RB];
        2'b01:   en = alt_oe_i[0][n];
        2'b10:   en = alt_oe_i[1][n];
        default: en = alt_oe_i[2][n];
      endcase
    end

    assign od           = ode_w_i[RB];
    assign pad_out_o[n] = od ? 1'b0 : val;
    assign pad_oe_o[n]  = od ? (en & ~val) : en;

    // R7
    od_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ode_w_i[RB] |-> (pad_out_o[n] == 1'b0));
    // R5
    float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tsl_w_i == '0 && tsh_w_i == '0 && !drv_w_i[RB]) |-> !pad_oe_o[n]);
  end
endmodule

// File: rtl/pinbank_top.sv
module pinbank_top
  import pinbank_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [4:0]           addr_i,
  input  logic [3:0]           be_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [2:0][31:0]     alt_val_i,
  input  logic [2:0][31:0]     alt_oe_i,
  input  logic [31:0]          pad_in_i,
  output logic [31:0]          pad_out_o,
  output logic [31:0]          pad_oe_o
);
  logic [DW-1:0] out_w, drv_w, osl_w, osh_w, tsl_w, tsh_w, ode_w;
  logic [NPIN-1:0] pin_sync;
  logic [DW-1:0]   in_word;

  pinbank_sync #(.W(NPIN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_sync)
  );

  for (genvar n = 0; n < NPIN; n++) begin : g_rev
    assign in_word[DW-1-n] = pin_sync[n];
  end

  pinbank_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .be_i      (be_i),
    .wdata_i   (wdata_i),
    .in_word_i (in_word),
    .rdata_o   (rdata_o),
    .out_w_o   (out_w),
    .drv_w_o   (drv_w),
    .osl_w_o   (osl_w),
    .osh_w_o   (osh_w),
    .tsl_w_o   (tsl_w),
    .tsh_w_o   (tsh_w),
    .ode_w_o   (ode_w)
  );

  pinbank_pinmux u_mux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .out_w_i   (out_w),
    .drv_w_i   (drv_w),
    .osl_w_i   (osl_w),
    .osh_w_i   (osh_w),
    .tsl_w_i   (tsl_w),
    .tsh_w_i   (tsh_w),
    .ode_w_i   (ode_w),
    .alt_val_i (alt_val_i),
    .alt_oe_i  (alt_oe_i),
    .pad_out_o (pad_out_o),
    .pad_oe_o  (pad_oe_o)
  );
endmodule

// File: tb/sim_pinbank_top.sv
module sim_pinbank_top;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [4:0]      addr = '0;
  logic [3:0]      be = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [2:0][31:0] alt_val = '0;
  logic [2:0][31:0] alt_oe = '0;
  logic [31:0]     pad_in = '0;
  logic [31:0]     pad_out, pad_oe;

  int tests = 0;
  int fails = 0;
  logic [31:0] sh [18];
  logic [31:0] pad_seen;  // pad_in value visible in word 7

  always #(CLK_PERIOD/2) clk = ~clk;

  pinbank_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .be_i(be),
    .wdata_i(wdata), .rdata_o(rdata), .alt_val_i(alt_val), .alt_oe_i(alt_oe),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  function automatic logic [31:0] rev32(logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = v[i];
    return r;
  endfunction

  function automatic logic [1:0] fld(logic [31:0] lo, logic [31:0] hi, int n);
    logic [31:0] w;
    w = (n < 16) ? lo : hi;
    return w[30 - 2*(n % 16) +: 2];
  endfunction

  // expected pads: {oe, out}
  function automatic logic [63:0] exp_pads();
    logic [31:0] eo, ee;
    for (int n = 0; n < 32; n++) begin
      logic [1:0] vs, es;
      logic v, e, od;
      vs = fld(sh[2], sh[3], n);
      es = fld(sh[4], sh[5], n);
      v  = (vs == 2'b00) ? sh[0][31-n] : alt_val[vs-1][n];
      e  = (es == 2'b00) ? sh[1][31-n] : alt_oe[es-1][n];
      od = sh[6][31-n];
      eo[n] = od ? 1'b0 : v;
      ee[n] = od ? (e & ~v) : e;
    end
    return {ee, eo};
  endfunction

  function automatic logic [31:0] exp_read(logic [4:0] a);
    if (a == 5'd7) return rev32(pad_seen);
    if (a == 5'd11 || a >= 5'd18) return '0;
    return sh[a];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, logic [3:0] b);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; be = b;
    if (a < 5'd18 && a != 5'd7 && a != 5'd11)
      for (int i = 0; i < 4; i++) if (b[i]) sh[a][i*8 +: 8] = d[i*8 +: 8];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [4:0] a);
    addr = a;
    #1;
    chk(req, {32'd0, rdata}, {32'd0, exp_read(a)});
  endtask

  task automatic pad_chk(string req);
    #1;
    chk(req, {pad_oe, pad_out}, exp_pads());
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 18; i++) sh[i] = '0;
    pad_seen = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 18; a++) if (a != 7) rd_chk("R1", 5'(a));
    chk("R1 oe", {32'd0, pad_oe}, 64'd0);

    // R2/R5 pin 0 is MSB: drive pin 0 high
    wr(5'd0, 32'h8000_0000, 4'hF);
    wr(5'd1, 32'h8000_0000, 4'hF);
    chk("R2", {pad_oe, pad_out}, {32'h1, 32'h1});
    pad_chk("R5");

    // R4/R6 pin 16 value from alt1, enable from alt3
    alt_val[0] = 32'h0001_0000;
    alt_oe[2]  = 32'h0001_0000;
    wr(5'd3, 32'h4000_0000, 4'hF);
    wr(5'd5, 32'hC000_0000, 4'hF);
    chk("R4", {31'd0, pad_oe[16], 31'd0, pad_out[16]}, {31'd0, 1'b1, 31'd0, 1'b1});
    pad_chk("R6");
    // pin 15 field in low word bits 1:0 = alt2
    alt_val[1] = 32'h0000_8000;
    wr(5'd2, 32'h0000_0002, 4'hF);
    chk("R4 pin15", {63'd0, pad_out[15]}, 64'd1);

    // R7 open drain on pin 0, value 1 then 0
    wr(5'd6, 32'h8000_0000, 4'hF);
    chk("R7 v1", {31'd0, pad_oe[0], 31'd0, pad_out[0]}, 64'd0);
    wr(5'd0, 32'h0000_0000, 4'hF);
    chk("R7 v0", {31'd0, pad_oe[0], 31'd0, pad_out[0]}, {31'd0, 1'b1, 32'd0});

    // R8 exact two-edge latency
    pad_in = 32'h0000_0001;
    @(negedge clk);
    rd_chk("R8 one edge", 5'd7);
    @(negedge clk);
    pad_seen = pad_in;
    addr = 5'd7; #1;
    chk("R8 two edges", {32'd0, rdata}, {32'd0, 32'h8000_0000});

    // R9 read-only and reserved
    wr(5'd7, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R9 in", 5'd7);
    wr(5'd11, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R9 rsv", 5'd11);

    // R10 byte enables
    wr(5'd8, 32'hA5A5_A5A5, 4'hF);
    wr(5'd8, 32'h1234_5678, 4'b0100);
    addr = 5'd8; #1;
    chk("R10", {32'd0, rdata}, {32'd0, 32'hA534_A5A5});
    wr(5'd6, 32'hFFFF_FFFF, 4'b0000);
    pad_chk("R10 none");

    // R11 storage words, R3 out of range
    wr(5'd17, 32'hDEAD_BEEF, 4'hF);
    rd_chk("R11", 5'd17);
    pad_chk("R11 pads");
    wr(5'd20, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R3 oor", 5'd20);
    pad_chk("R3 oor pads");

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [4:0] a;
      @(negedge clk);
      pad_in = $urandom;
      for (int k = 0; k < 3; k++) begin
        alt_val[k] = $urandom;
        alt_oe[k]  = $urandom;
      end
      a = 5'($urandom_range(0, 19));
      wr(a, $urandom, 4'($urandom));
      pad_seen = pad_in;
      pad_chk("R5 R6 R7 rand");
      rd_chk("R3 R11 rand", 5'($urandom_range(0, 21)));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule